// File: doc/BRIEF.md
# Trigger-Driven Synthetic Event Replayer

This block holds one synthetic event in a local word memory and pushes a prefix of it into an event stream each time a trigger rises while replay is armed. Software fills the memory over a simple register bus, programs how many words make up the event, and sets the arm bit. From then on, a rising edge on the trigger input starts a replay that sends memory words 0 through length-1, in order, on a valid/ready output that feeds the write side of an event FIFO.

The stream follows normal valid/ready rules. `ev_valid` rises the cycle after the trigger edge. A word is taken on each clock edge where both `ev_valid` and `ev_ready` are high. While `ev_ready` is low, `ev_valid` and `ev_data` hold. While replay is armed or running, the bus cannot reach the memory: reads return zero and writes are dropped.

The block also counts trigger rising edges, keeps a sticky bit that records that the trigger was seen high, and shows the live trigger level.

Top module: `fake_event_player`

## Requirements
- R1: After reset, the control, catch and count registers read 0 and `ev_valid` is low.
- R2: The control register at 0x0000 holds the event length in bits 9:0 and the arm bit in bit 16. It reads back those fields, and all other bits read 0.
- R3: A bus read returns its data on `bus_rdata` in the cycle after `bus_rd_en`. While the block is not armed, words written at byte addresses 0x8000 to 0x8FFC (word index taken from address bits 11:2) read back unchanged.
- R4: While the arm bit is set or a replay is running, memory reads return 0 and memory writes are dropped. The original word can be read again once the block is disarmed.
- R5: A trigger rising edge while armed, idle and with a nonzero length sends memory words 0 through length-1 in order. `ev_valid` is first high in the cycle after the edge.
- R6: While `ev_valid` is high and `ev_ready` is low, `ev_valid` stays high and `ev_data` does not change. No word is skipped or repeated.
- R7: With a length of 0, a trigger while armed produces no stream words.
- R8: A trigger edge during a running replay does not start or extend a replay, but it is still counted.
- R9: The count register at 0x000C increments once per trigger rising edge, not per cycle the trigger is high. Any write to it clears it to 0.
- R10: The catch register bit 0 at 0x0008 becomes 1 in any cycle the trigger is high. Writing 0 to bit 0 clears it while the trigger is low. Writing 1 has no effect.
- R11: The status register bit 0 at 0x0004 returns the trigger level sampled at the read.
- R12: A trigger edge while not armed produces no stream words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Bus write strobe |
| bus_rd_en | input | 1 | Bus read strobe |
| bus_addr | input | 16 | Bus byte address |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd_en` |
| trig_in | input | 1 | Trigger input, synchronous to `clk` |
| ev_valid | output | 1 | Stream word valid |
| ev_data | output | 32 | Stream word |
| ev_ready | input | 1 | FIFO can accept a word |

## Verification
The hardest case to reach is a replay that stalls under back-pressure and overlaps with other activity. In that case the memory read address must hold while `ev_ready` toggles, the output word must not change, and a second trigger edge must be counted without restarting the replay. The stimulus first starts a replay with `ev_ready` held low for several cycles, then toggles ready on every cycle. A separate run pulses the trigger again one cycle into a replay. A behavioural model compares every clock cycle, so a stalled word or a restarted index shows up in the exact cycle it goes wrong.

// File: rtl/fep_pkg.sv
package fep_pkg;
  typedef enum logic {PB_IDLE, PB_PLAY} pb_state_e;
  localparam logic [1:0] SEL_CTRL  = 2'd0;
  localparam logic [1:0] SEL_STAT  = 2'd1;
  localparam logic [1:0] SEL_CATCH = 2'd2;
  localparam logic [1:0] SEL_COUNT = 2'd3;
  localparam int MODE_BIT = 16;
endpackage

// File: rtl/fep_ram.sv
module fep_ram #(
  parameter int AW = 10,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 2 ** AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    q <= mem[addr];
  end
endmodule

// File: rtl/fep_regs.sv
module fep_regs
  import fep_pkg::*;
#(
  parameter int DW = 32,
  parameter int LW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [1:0]    sel,
  input  logic [DW-1:0] wdata,
  input  logic          trig_in,
  output logic          arm_mode,
  output logic [LW-1:0] arm_len,
  output logic          trig_rise,
  output logic [DW-1:0] rdata
);
  logic          trig_q, catch_r;
  logic [DW-1:0] cnt_r, rd_mux;
  logic          unused_wbits;

  assign unused_wbits = ^{wdata[DW-1:MODE_BIT+1], wdata[MODE_BIT-1:LW]};
  assign trig_rise    = trig_in & ~trig_q;

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_CTRL:  begin rd_mux[LW-1:0] = arm_len; rd_mux[MODE_BIT] = arm_mode; end
      SEL_STAT:  rd_mux[0] = trig_in;
      SEL_CATCH: rd_mux[0] = catch_r;
      default:   rd_mux = cnt_r;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q   <= 1'b0;
      catch_r  <= 1'b0;
      cnt_r    <= '0;
      arm_mode <= 1'b0;
      arm_len  <= '0;
      rdata    <= '0;
    end else begin
      trig_q <= trig_in;
      if (wr_en && sel == SEL_CTRL) begin
        arm_len  <= wdata[LW-1:0];
        arm_mode <= wdata[MODE_BIT];
      end
      if (wr_en && sel == SEL_COUNT) cnt_r <= '0;
      else if (trig_rise)            cnt_r <= cnt_r + 1'b1;
      if (trig_in)                                      catch_r <= 1'b1;
      else if (wr_en && sel == SEL_CATCH && !wdata[0])  catch_r <= 1'b0;
      if (rd_en) rdata <= rd_mux;
    end
  end

  // R9
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_r != $past(cnt_r)) |-> (cnt_r == $past(cnt_r) + 1'b1 || cnt_r == '0));

  // R10
  catch_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_in |=> catch_r);
endmodule

// File: rtl/fep_player.sv
module fep_player
  import fep_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_req,
  input  logic [AW-1:0] len,
  input  logic [DW-1:0] ram_q,
  input  logic          ev_ready,
  output logic          ev_valid,
  output logic [DW-1:0] ev_data,
  output logic          busy,
  output logic [AW-1:0] rd_addr
);
  pb_state_e     st;
  logic [AW-1:0] idx, plen;
  logic          fire, last;

  assign busy     = (st == PB_PLAY);
  assign ev_valid = busy;
  assign ev_data  = ram_q;
  assign fire     = busy && ev_ready;
  assign last     = (idx == plen - 1'b1);
  assign rd_addr  = busy ? idx + AW'(fire) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= PB_IDLE;
      idx  <= '0;
      plen <= '0;
    end else begin
      case (st)
        PB_IDLE: if (start_req && len != '0) begin
          st   <= PB_PLAY;
          idx  <= '0;
          plen <= len;
        end
        default: if (fire) begin
          if (last) st <= PB_IDLE;
          else      idx <= idx + 1'b1;
        end
      endcase
    end
  end

  // R6
  hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !ev_ready) |=> (ev_valid && $stable(ev_data)));

  // R7
  len_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> (plen != '0));

  // R5
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> (idx < plen));
endmodule

// File: rtl/fake_event_player.sv
module fake_event_player
  import fep_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr_en,
  input  logic          bus_rd_en,
  input  logic [15:0]   bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          trig_in,
  output logic          ev_valid,
  output logic [DW-1:0] ev_data,
  input  logic          ev_ready
);
  localparam logic [15:0] RAM_BASE = 16'h8000;

  logic          ram_sel, reg_sel, blocked, ram_we;
  logic          arm_mode, trig_rise, busy;
  logic [AW-1:0] arm_len, pl_addr, ram_addr;
  logic [DW-1:0] ram_q, reg_rdata;
  logic          rd_ram_q, rd_blk_q, rd_reg_q;

  assign ram_sel  = (bus_addr[15:AW+2] == RAM_BASE[15:AW+2]) && (bus_addr[1:0] == 2'b00);
  assign reg_sel  = (bus_addr[15:4] == 12'h000) && (bus_addr[1:0] == 2'b00);
  assign blocked  = arm_mode | busy;
  assign ram_we   = bus_wr_en & ram_sel & ~blocked;
  assign ram_addr = blocked ? pl_addr : bus_addr[AW+1:2];

  fep_regs #(.DW(DW), .LW(AW)) regs_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(bus_wr_en & reg_sel), .rd_en(bus_rd_en & reg_sel),
    .sel(bus_addr[3:2]), .wdata(bus_wdata), .trig_in(trig_in),
    .arm_mode(arm_mode), .arm_len(arm_len), .trig_rise(trig_rise),
    .rdata(reg_rdata)
  );

  fep_ram #(.AW(AW), .DW(DW)) ram_i (
    .clk(clk), .we(ram_we), .addr(ram_addr), .wdata(bus_wdata), .q(ram_q)
  );

  fep_player #(.AW(AW), .DW(DW)) player_i (
    .clk(clk), .rst_n(rst_n),
    .start_req(trig_rise & arm_mode), .len(arm_len),
    .ram_q(ram_q), .ev_ready(ev_ready),
    .ev_valid(ev_valid), .ev_data(ev_data),
    .busy(busy), .rd_addr(pl_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ram_q <= 1'b0;
      rd_blk_q <= 1'b0;
      rd_reg_q <= 1'b0;
    end else begin
      rd_ram_q <= bus_rd_en & ram_sel;
      rd_blk_q <= blocked;
      rd_reg_q <= bus_rd_en & reg_sel;
    end
  end

  assign bus_rdata = rd_ram_q ? (rd_blk_q ? '0 : ram_q) : (rd_reg_q ? reg_rdata : '0);

  // R4
  lock_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> !ram_we);
endmodule

// File: tb/fake_event_player_tb.sv
module fake_event_player_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        bus_wr_en = 0, bus_rd_en = 0, trig_in = 0, ev_ready = 0;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata, ev_data;
  logic        ev_valid;

  always #5 clk = ~clk;

  fake_event_player dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .trig_in(trig_in), .ev_valid(ev_valid), .ev_data(ev_data), .ev_ready(ev_ready)
  );

  int total = 0, bad = 0, cyc = 0;
  logic [31:0] got[$];

  function automatic void chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endfunction

  function automatic logic [31:0] word(int i);
    return 32'hA500_0000 + 32'(i) * 32'h0001_0203;
  endfunction

  // behavioural reference model
  bit [31:0] m_mem [1024];
  bit        m_mode, m_busy, m_trigq, m_catch, m_rdp;
  bit [9:0]  m_len, m_plen, m_idx;
  bit [31:0] m_cnt, m_rdx;

  always @(posedge clk) begin
    bit blk, rise;
    bit [9:0] w;
    if (!rst_n) begin
      m_mode = 0; m_busy = 0; m_trigq = 0; m_catch = 0; m_rdp = 0;
      m_len = 0; m_plen = 0; m_idx = 0; m_cnt = 0; m_rdx = 0;
    end else begin
      blk  = m_mode || m_busy;
      rise = trig_in && !m_trigq;
      w    = bus_addr[11:2];
      m_rdp = bus_rd_en;
      m_rdx = 0;
      if (bus_addr[15:12] == 4'h8 && bus_addr[1:0] == 0) m_rdx = blk ? 0 : m_mem[w];
      else if (bus_addr[15:4] == 0 && bus_addr[1:0] == 0)
        case (bus_addr[3:2])
          2'd0: m_rdx = {15'd0, m_mode, 6'd0, m_len};
          2'd1: m_rdx = {31'd0, trig_in};
          2'd2: m_rdx = {31'd0, m_catch};
          default: m_rdx = m_cnt;
        endcase
      if (m_busy && ev_ready) begin
        if (m_idx == m_plen - 1) m_busy = 0; else m_idx++;
      end else if (!m_busy && rise && m_mode && m_len != 0) begin
        m_busy = 1; m_idx = 0; m_plen = m_len;
      end
      if (bus_wr_en && bus_addr == 16'h000C) m_cnt = 0;
      else if (rise) m_cnt++;
      if (trig_in) m_catch = 1;
      else if (bus_wr_en && bus_addr == 16'h0008 && !bus_wdata[0]) m_catch = 0;
      if (bus_wr_en && bus_addr == 16'h0000) begin
        m_len = bus_wdata[9:0]; m_mode = bus_wdata[16];
      end
      if (bus_wr_en && bus_addr[15:12] == 4'h8 && bus_addr[1:0] == 0 && !blk) m_mem[w] = bus_wdata;
      m_trigq = trig_in;
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk(ev_valid == m_busy, "R5 ev_valid vs model", 32'(ev_valid), 32'(m_busy));
    if (m_busy) chk(ev_data == m_mem[m_idx], "R6 ev_data vs model", ev_data, m_mem[m_idx]);
    if (m_rdp) chk(bus_rdata == m_rdx, "R3 bus_rdata vs model", bus_rdata, m_rdx);
    if (ev_valid && ev_ready) got.push_back(ev_data);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=<50000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic tick(); @(posedge clk); #2; endtask
  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    bus_wr_en = 1; bus_addr = a; bus_wdata = d; tick(); bus_wr_en = 0;
  endtask
  task automatic rd(input logic [15:0] a, input logic [31:0] e, input string tag);
    bus_rd_en = 1; bus_addr = a; tick(); bus_rd_en = 0;
    @(negedge clk); chk(bus_rdata == e, tag, bus_rdata, e);
    @(posedge clk); #2;
  endtask
  task automatic pulse(int n);
    trig_in = 1; repeat (n) tick(); trig_in = 0; tick();
  endtask
  task automatic wait_idle();
    for (int k = 0; k < 500 && ev_valid; k++) tick();
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1; tick();
    chk(ev_valid == 0, "R1 ev_valid after reset", 32'(ev_valid), 0);
    rd(16'h0000, 0, "R1 ctrl reset");
    rd(16'h0008, 0, "R1 catch reset");
    rd(16'h000C, 0, "R1 count reset");
    wr(16'h0000, 32'hFFFE_FC05);
    rd(16'h0000, 32'h0000_0005, "R2 ctrl field masking");
    for (int i = 0; i < 20; i++) wr(16'(16'h8000 + i * 4), word(i));
    wr(16'h8FFC, 32'h1234_5678);
    rd(16'h800C, word(3), "R3 ram readback");
    rd(16'h8FFC, 32'h1234_5678, "R3 ram top word");
    got.delete();
    ev_ready = 1;
    pulse(1); repeat (3) tick();
    chk(got.size() == 0, "R12 unarmed trigger no stream", got.size(), 0);
    rd(16'h000C, 1, "R9 count one edge");
    wr(16'h0000, 32'h0001_0005);
    rd(16'h0000, 32'h0001_0005, "R2 arm readback");
    rd(16'h8008, 0, "R4 locked read zero");
    wr(16'h8008, 32'hDEAD_BEEF);
    got.delete();
    trig_in = 1; tick(); trig_in = 0; tick(); trig_in = 1; tick(); trig_in = 0;
    wait_idle(); repeat (3) tick();
    chk(got.size() == 5, "R8 retrigger ignored", got.size(), 5);
    for (int i = 0; i < 5 && i < got.size(); i++) chk(got[i] == word(i), "R5 stream order", got[i], word(i));
    rd(16'h000C, 3, "R8 ignored edge counted");
    wr(16'h0000, 32'h0001_0007);
    got.delete();
    ev_ready = 0;
    pulse(1); repeat (3) tick();
    for (int k = 0; k < 20; k++) begin ev_ready = k[0]; tick(); end
    ev_ready = 1;
    wait_idle(); tick();
    chk(got.size() == 7, "R6 backpressure word count", got.size(), 7);
    for (int i = 0; i < 7 && i < got.size(); i++) chk(got[i] == word(i), "R6 backpressure order", got[i], word(i));
    wr(16'h0000, 32'h0000_0005);
    rd(16'h8008, word(2), "R4 locked write dropped");
    wr(16'h0000, 32'h0001_0000);
    got.delete();
    pulse(1); repeat (5) tick();
    chk(got.size() == 0, "R7 zero length no stream", got.size(), 0);
    wr(16'h0000, 0);
    wr(16'h0008, 0);
    rd(16'h0008, 0, "R10 catch cleared");
    trig_in = 1;
    rd(16'h0004, 1, "R11 status high");
    rd(16'h0008, 1, "R10 catch set by level");
    trig_in = 0; tick();
    rd(16'h000C, 6, "R9 level counted once");
    rd(16'h0004, 0, "R11 status low");
    wr(16'h0008, 1);
    rd(16'h0008, 1, "R10 write one keeps catch");
    wr(16'h0008, 0);
    rd(16'h0008, 0, "R10 write zero clears");
    wr(16'h000C, 32'hFFFF_FFFF);
    rd(16'h000C, 0, "R9 write clears count");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule